// File: doc/BRIEF.md
# Rotate and Wraparound Mask Unit

This block is the combinational core of the rotate-type integer operations. It rotates a 64-bit source left by a 6-bit amount, either as a full doubleword or as a word whose low 32 bits are first copied into both halves of the value. Alongside the rotation it builds a contiguous mask from a begin index and an end index. When begin is greater than end the mask wraps around the word.

Bit indices are counted from the most significant end, so index 0 is the MSB. The block presents three outputs: the rotated value, the mask, and the bitwise AND of the two. An instruction pipeline feeds the fields it has decoded straight into the inputs and takes the outputs in the same cycle. Merging the result into a destination register and updating condition codes are done elsewhere. For word forms, the caller adds 32 to the mask bounds before they reach this block.

Top module: `rotmask_unit`

## Requirements
- R1: A mask index i refers to vector bit 63-i: index 0 is bit 63 (MSB) and index 63 is bit 0 (LSB). For example, begin=32 and end=32 give 0x0000000080000000, and begin=0 and end=10 give 0xffe0000000000000.
- R2: When begin < end, mask_o holds ones at indices begin through end inclusive and zeros at every other index. For example, begin=37 and end=63 give 0x0000000007ffffff.
- R3: When begin equals end, mask_o has exactly one bit set, at index begin.
- R4: When begin > end, mask_o holds ones at indices begin through 63 and at indices 0 through end, and zeros elsewhere. For example, begin=47 and end=37 give 0xfffffffffc01ffff.
- R5: With word_mode_i=0, rotated_o is src_i rotated left by amount_i over 64 bits. For example, 0xdeadbeef12345678 rotated by 10 gives 0xb6fbbc48d159e37a.
- R6: With word_mode_i=1, rotated_o is {src_i[31:0], src_i[31:0]} rotated left by amount_i modulo 32. Bit 5 of amount_i has no effect. For example, a source of 0xdeadbeef rotated by 10 gives 0xb6fbbf7a in the low word, and the high word equals the low word.
- R7: result_o equals rotated_o AND mask_o, bit by bit.
- R8: With word_mode_i=1, src_i[63:32] has no effect on any output.
- R9: All outputs are combinational: they follow a change of any input within the same cycle, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source value to rotate |
| amount_i | input | 6 | Left-rotate count |
| word_mode_i | input | 1 | 1: 32-bit rotation of the duplicated low word; 0: 64-bit rotation |
| mask_begin_i | input | 6 | First mask index, counted from the MSB |
| mask_end_i | input | 6 | Last mask index, counted from the MSB |
| rotated_o | output | 64 | Rotated value |
| mask_o | output | 64 | Generated mask |
| result_o | output | 64 | Rotated value ANDed with the mask |

## Verification
Random mask bounds hit the three ordering cases of begin and end: ordered, equal and reversed. The expected mask is computed one index at a time, so a mistake in the order of bits, in the inclusive ends or in the wrap shows up as a mismatch. Random rotate amounts cover every shift stage in both modes. In word mode the stimulus includes amounts at or above 32 and junk in the upper source half, which shows whether the amount is reduced to 5 bits and whether the low word is duplicated. The known vectors for masks and rotations tie the bit numbering to absolute values.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

  localparam int DATA_W = 64;

  typedef enum logic {
    ROT_DWORD = 1'b0,
    ROT_WORD  = 1'b1
  } rot_mode_e;

endpackage

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int XLEN = 64,
  localparam int AW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] src_i,
  input  logic [AW-1:0]   amt_i,
  input  logic            word_mode_i,
  output logic [XLEN-1:0] dup_o,
  output logic [AW-1:0]   amt_eff_o,
  output logic [XLEN-1:0] rot_o
);
  import rotmask_pkg::*;

  localparam int HALF = XLEN / 2;
  localparam logic [AW-1:0] HALF_MASK = AW'(HALF - 1);

  // Copy the low half into both halves when word rotation is selected.
  function automatic logic [XLEN-1:0] spread_low(input logic [XLEN-1:0] v,
                                                 input logic wm);
    return (rot_mode_e'(wm) == ROT_WORD) ? {v[HALF-1:0], v[HALF-1:0]} : v;
  endfunction

  // Reduce the rotate count to the word length.
  function automatic logic [AW-1:0] wrap_amount(input logic [AW-1:0] a,
                                                input logic wm);
    return (rot_mode_e'(wm) == ROT_WORD) ? (a & HALF_MASK) : a;
  endfunction

  logic [XLEN-1:0] stage [0:AW];

  assign dup_o     = spread_low(src_i, word_mode_i);
  assign amt_eff_o = wrap_amount(amt_i, word_mode_i);
  assign stage[0]  = dup_o;

  // One stage per amount bit; stage s rotates left by 2**s.
  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt_eff_o[s]
                      ? {stage[s][XLEN-1-SH:0], stage[s][XLEN-1:XLEN-SH]}
                      : stage[s];
  end

  assign rot_o = stage[AW];

endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
  parameter int XLEN = 64,
  localparam int AW = $clog2(XLEN)
) (
  input  logic [AW-1:0]   begin_i,
  input  logic [AW-1:0]   end_i,
  output logic            wrap_o,
  output logic [XLEN-1:0] mask_o
);

  // Ones at indices b..XLEN-1 (index 0 = MSB).
  function automatic logic [XLEN-1:0] ones_from(input logic [AW-1:0] b);
    return {XLEN{1'b1}} >> b;
  endfunction

  // Ones at indices 0..e (index 0 = MSB).
  function automatic logic [XLEN-1:0] ones_through(input logic [AW-1:0] e);
    logic [AW:0] sh;
    sh = {1'b0, e} + 1'b1;
    return ~({XLEN{1'b1}} >> sh);
  endfunction

  logic [XLEN-1:0] from_w;
  logic [XLEN-1:0] thru_w;

  assign from_w = ones_from(begin_i);
  assign thru_w = ones_through(end_i);
  assign wrap_o = begin_i > end_i;
  assign mask_o = wrap_o ? (from_w | thru_w) : (from_w & thru_w);

endmodule

// File: rtl/rm_merge.sv
module rm_merge #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rot_i,
  input  logic [XLEN-1:0] mask_i,
  output logic [XLEN-1:0] res_o
);

  function automatic logic [XLEN-1:0] keep_bits(input logic [XLEN-1:0] v,
                                                input logic [XLEN-1:0] m);
    return v & m;
  endfunction

  assign res_o = keep_bits(rot_i, mask_i);

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int XLEN = rotmask_pkg::DATA_W,
  localparam int AW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] src_i,
  input  logic [AW-1:0]   amount_i,
  input  logic            word_mode_i,
  input  logic [AW-1:0]   mask_begin_i,
  input  logic [AW-1:0]   mask_end_i,
  output logic [XLEN-1:0] rotated_o,
  output logic [XLEN-1:0] mask_o,
  output logic [XLEN-1:0] result_o
);

  // Named internal events, brought out for the checker.
  logic [XLEN-1:0] dup_w;
  logic [AW-1:0]   amt_eff_w;
  logic            wrap_w;

  rm_rotator #(.XLEN(XLEN)) u_rot (
    .src_i       (src_i),
    .amt_i       (amount_i),
    .word_mode_i (word_mode_i),
    .dup_o       (dup_w),
    .amt_eff_o   (amt_eff_w),
    .rot_o       (rotated_o)
  );

  rm_mask_gen #(.XLEN(XLEN)) u_mask (
    .begin_i (mask_begin_i),
    .end_i   (mask_end_i),
    .wrap_o  (wrap_w),
    .mask_o  (mask_o)
  );

  rm_merge #(.XLEN(XLEN)) u_merge (
    .rot_i  (rotated_o),
    .mask_i (mask_o),
    .res_o  (result_o)
  );

endmodule

// File: rtl/rotmask_checker.sv
module rotmask_checker #(
  parameter int XLEN = 64,
  localparam int AW = $clog2(XLEN)
) (
  input logic [XLEN-1:0] src_i,
  input logic            word_mode_i,
  input logic [AW-1:0]   mask_begin_i,
  input logic [AW-1:0]   mask_end_i,
  input logic [XLEN-1:0] rotated_o,
  input logic [XLEN-1:0] mask_o,
  input logic [XLEN-1:0] result_o,
  input logic [XLEN-1:0] dup_w,
  input logic [AW-1:0]   amt_eff_w,
  input logic            wrap_w
);
  localparam int HALF = XLEN / 2;

  int exp_cnt;

  always_comb begin
    if (mask_begin_i <= mask_end_i)
      exp_cnt = int'(mask_end_i) - int'(mask_begin_i) + 1;
    else
      exp_cnt = XLEN - int'(mask_begin_i) + int'(mask_end_i) + 1;
  end

  always_comb begin
    // The indices named by begin and end are always inside the mask.
    assert_bounds_set_R1: assert (mask_o[XLEN-1-int'(mask_begin_i)] &&
                                  mask_o[XLEN-1-int'(mask_end_i)]);
    // R2 / R4: the number of ones matches the span, with or without wrap.
    assert_mask_count_R2: assert ($countones(mask_o) == exp_cnt);
    assert_single_bit_R3: assert (!(mask_begin_i == mask_end_i) ||
                                  $onehot(mask_o));
    assert_wrap_ends_R4: assert (!wrap_w || (mask_o[XLEN-1] && mask_o[0]));
    // A rotation never changes the population of the value it moves.
    assert_rot_pop_R5: assert ($countones(rotated_o) == $countones(dup_w));
    assert_word_halves_R6: assert (!word_mode_i ||
                                   (rotated_o[XLEN-1:HALF] == rotated_o[HALF-1:0]));
    assert_word_amt_R6: assert (!word_mode_i || !amt_eff_w[AW-1]);
    assert_res_inside_R7: assert ((result_o & ~mask_o) == '0);
    assert_res_agrees_R7: assert (((result_o ^ rotated_o) & mask_o) == '0);
    assert_low_word_R8: assert (!word_mode_i ||
                                (dup_w[HALF-1:0] == src_i[HALF-1:0]));
  end

endmodule

bind rotmask_unit rotmask_checker #(.XLEN(XLEN)) u_chk (
  .src_i        (src_i),
  .word_mode_i  (word_mode_i),
  .mask_begin_i (mask_begin_i),
  .mask_end_i   (mask_end_i),
  .rotated_o    (rotated_o),
  .mask_o       (mask_o),
  .result_o     (result_o),
  .dup_w        (dup_w),
  .amt_eff_w    (amt_eff_w),
  .wrap_w       (wrap_w)
);

// File: tb/sim_rotmask_unit.sv
module sim_rotmask_unit;

  logic        clk = 1'b0;
  logic [63:0] src;
  logic [5:0]  amt;
  logic        wm;
  logic [5:0]  mb;
  logic [5:0]  me;
  logic [63:0] rot_q;
  logic [63:0] mask_q;
  logic [63:0] res_q;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rotmask_unit u0 (
    .src_i        (src),
    .amount_i     (amt),
    .word_mode_i  (wm),
    .mask_begin_i (mb),
    .mask_end_i   (me),
    .rotated_o    (rot_q),
    .mask_o       (mask_q),
    .result_o     (res_q)
  );

  function automatic logic [63:0] ref_mask(input int b, input int e);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) begin
      if (b <= e) m[63-i] = (i >= b) && (i <= e);
      else        m[63-i] = (i >= b) || (i <= e);
    end
    return m;
  endfunction

  function automatic logic [63:0] ref_rot(input logic [63:0] v, input int a,
                                          input logic word);
    logic [63:0] x;
    logic [63:0] o = '0;
    int n;
    x = word ? {v[31:0], v[31:0]} : v;
    n = word ? (a % 32) : (a % 64);
    for (int i = 0; i < 64; i++) o[(i + n) % 64] = x[i];
    return o;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] s, input int a, input logic w,
                       input int b, input int e);
    @(negedge clk);
    src = s; amt = 6'(a); wm = w; mb = 6'(b); me = 6'(e);
    #2;
  endtask

  task automatic full_check(input logic [63:0] s, input int a, input logic w,
                            input int b, input int e);
    logic [63:0] em;
    logic [63:0] er;
    em = ref_mask(b, e);
    er = ref_rot(s, a, w);
    if (b < e)       chk("R2", mask_q, em);
    else if (b == e) chk("R3", mask_q, em);
    else             chk("R4", mask_q, em);
    chk(w ? "R6" : "R5", rot_q, er);
    chk("R7", res_q, er & em);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    logic [63:0] r_prev;
    int a, b, e;
    logic w;
    void'($urandom(32'd20240611));

    // Initial inputs, then the fixed vectors.
    apply(64'h0, 0, 1'b0, 0, 63);
    chk("R9", mask_q, 64'hffffffffffffffff);
    chk("R9", rot_q, 64'h0);

    apply(64'hffffffffffffffff, 0, 1'b0, 37, 63);
    chk("R2", mask_q, 64'h0000000007ffffff);
    chk("R7", res_q, 64'h0000000007ffffff);
    apply(64'hffffffffffffffff, 0, 1'b0, 47, 37);
    chk("R4", mask_q, 64'hfffffffffc01ffff);
    apply(64'hffffffffffffffff, 0, 1'b0, 0, 10);
    chk("R1", mask_q, 64'hffe0000000000000);
    apply(64'hffffffffffffffff, 0, 1'b0, 32, 32);
    chk("R1", mask_q, 64'h0000000080000000);
    chk("R3", res_q, 64'h0000000080000000);
    apply(64'hffffffffffffffff, 0, 1'b0, 63, 0);
    chk("R4", mask_q, 64'h8000000000000001);
    apply(64'hffffffffffffffff, 0, 1'b0, 0, 63);
    chk("R2", mask_q, 64'hffffffffffffffff);

    apply(64'hdeadbeef12345678, 10, 1'b0, 0, 63);
    chk("R5", rot_q, 64'hb6fbbc48d159e37a);
    apply(64'h00000000deadbeef, 10, 1'b1, 32, 63);
    chk("R6", rot_q[31:0], 32'hb6fbbf7a);
    chk("R6", rot_q[63:32], 32'hb6fbbf7a);
    chk("R7", res_q, 64'h00000000b6fbbf7a);
    r_prev = rot_q;
    // Bit 5 of the amount and the upper source half are ignored in word mode.
    apply(64'h123456789abcdef0 ^ 64'h00000000deadbeef ^ 64'h000000009abcdef0,
          42, 1'b1, 32, 63);
    chk("R6", rot_q, r_prev);
    apply(64'hcafef00ddeadbeef, 10, 1'b1, 32, 63);
    chk("R8", rot_q, r_prev);
    chk("R8", res_q, 64'h00000000b6fbbf7a);
    apply(64'h8000000000000001, 63, 1'b0, 0, 0);
    chk("R5", rot_q, 64'hc000000000000000);
    chk("R7", res_q, 64'h8000000000000000);

    // Random stimulus against the bench reference.
    for (int k = 0; k < 2000; k++) begin
      s = {$urandom(), $urandom()};
      a = int'($urandom_range(0, 63));
      w = 1'($urandom_range(0, 1));
      b = int'($urandom_range(0, 63));
      e = (k % 7 == 0) ? b : int'($urandom_range(0, 63));
      apply(s, a, w, b, e);
      full_check(s, a, w, b, e);
      if (w) begin
        r_prev = rot_q;
        apply({~s[63:32], s[31:0]}, a, w, b, e);
        chk("R8", rot_q, r_prev);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule